// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits beside a direct-mapped cache and keeps lines that the cache pushed out because of an index collision. The cache controller uses two request inputs. A lookup request carries the full line address (tag and index) of a main-cache miss, and every slot is compared against it at once. An eviction request carries the line the main cache is displacing, with its address, data and modified flag.

When a lookup finds its line, the line is handed back with its modified flag so the main cache can reinstall it. That slot is freed. If an eviction arrives in the same cycle, the displaced main-cache line goes into that same slot, so the two lines trade places. When a lookup misses in both places, the controller fetches from the next level and presents the displaced line as an eviction. The eviction fills a free slot, or the least recently filled slot when none is free. A modified line pushed out that way leaves on the writeback port. An unmodified one is dropped.

All outputs are registered and change one cycle after the request. The slot count is a parameter from 1 to 8.

Top module: `victim_buf`

## Requirements
- R1: While reset is high and on the cycle after it, all slots are empty and `look_done`, `look_hit` and `wb_valid` are 0. A lookup made right after reset misses.
- R2: A lookup (`look_req`=1) whose full line address matches a stored line gives `look_done`=1 and `look_hit`=1 on the next cycle. `look_data` and `look_dirty` on that cycle are the stored line's data and modified flag.
- R3: A lookup that matches no stored line gives `look_done`=1 and `look_hit`=0 on the next cycle.
- R4: A lookup hit with no eviction in the same cycle removes the line, so a repeated lookup of that address misses.
- R5: A lookup hit together with an eviction stores the evicted line in the freed slot. No writeback happens, and a later lookup of the evicted address returns its data and flag.
- R6: An eviction into a buffer with a free slot stores the line and raises no writeback.
- R7: An eviction into a full buffer replaces the line whose last fill (insertion or swap-in) is the oldest.
- R8: When R7 replaces a modified line, `wb_valid`=1 on the next cycle with that line's address on `wb_addr` and its data on `wb_data`. A replaced unmodified line gives `wb_valid`=0.
- R9: With a single slot the buffer keeps one line, returns it on lookup, and writes back a modified line when the next eviction replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| look_req | input | 1 | Lookup request for a main-cache miss |
| look_addr | input | ADDR_W | Full line address to search |
| ev_req | input | 1 | Line displaced from the main cache |
| ev_addr | input | ADDR_W | Line address of the displaced line |
| ev_data | input | DATA_W | Data of the displaced line |
| ev_dirty | input | 1 | Modified flag of the displaced line |
| look_done | output | 1 | Lookup result valid (one cycle after the request) |
| look_hit | output | 1 | Lookup found the line |
| look_data | output | DATA_W | Data of the found line |
| look_dirty | output | 1 | Modified flag of the found line |
| wb_valid | output | 1 | A modified line is leaving the buffer |
| wb_addr | output | ADDR_W | Line address of the leaving line |
| wb_data | output | DATA_W | Data of the leaving line |

## Verification
A lookup and an eviction can arrive in the same cycle in two ways. A lookup hit together with an eviction is a swap. A lookup miss together with an eviction into a full buffer is a replacement, possibly with a writeback. The bench runs a direct-mapped cache model with four sets and sixteen line addresses, so collisions are frequent and both cases occur many times along with directed cases. Every outcome is judged against a bench model that tracks lines and fill order with timestamps. Each line's data is followed through the cache, the buffer and memory, so a line that is lost or duplicated shows up as wrong data.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // Kind of update applied to the slot array in one cycle
  typedef enum logic [1:0] {
    VB_IDLE = 2'd0,
    VB_TAKE = 2'd1,  // lookup hit, slot emptied
    VB_SWAP = 2'd2,  // lookup hit, evicted line takes the slot
    VB_FILL = 2'd3   // eviction into free or oldest slot
  } vb_op_e;

  function automatic int vb_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              slot_valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0]  slot_addr,
  input  logic [ADDR_W-1:0]               key,
  output logic                            any_hit,
  output logic [IDX_W-1:0]                hit_idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = slot_valid[g] && (slot_addr[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (match[j]) hit_idx = hit_idx | IDX_W'(j);
  end
  assign any_hit = |match;

  // R2: a line address lives in at most one slot
  p_single_match_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] slot_valid,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  output logic               free_any,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0]   age [ENTRIES];
  logic [ENTRIES-1:0] age_zero;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) age[g] <= IDX_W'(g);
      else if (touch) begin
        if (IDX_W'(g) == touch_idx)     age[g] <= '0;
        else if (age[g] < age[touch_idx]) age[g] <= age[g] + 1'b1;
      end
    end
    assign age_zero[g] = (age[g] == '0);
  end

  // Lowest empty slot first, else the slot with the oldest fill
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int j = 0; j < ENTRIES; j++)
      if (!slot_valid[j] && !found) begin
        victim_idx = IDX_W'(j);
        found      = 1'b1;
      end
    free_any = found;
    if (!found)
      for (int j = 0; j < ENTRIES; j++)
        if (age[j] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(j);
  end

  // R7: ages stay a permutation, exactly one most recent slot
  p_one_newest_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(age_zero) == 1);
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              look_req,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              ev_req,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              look_done,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data,
  output logic              look_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import vb_pkg::*;
  localparam int IDX_W = vb_idx_w(ENTRIES);

  logic [ENTRIES-1:0]             slot_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr;
  logic [DATA_W-1:0]              slot_data [ENTRIES];
  logic [ENTRIES-1:0]             slot_dirty;

  logic             any_hit, free_any, take, spill;
  logic [IDX_W-1:0] hit_idx, victim_idx, tgt;
  vb_op_e           op;

  vb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_match (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .slot_addr(slot_addr),
    .key(look_addr), .any_hit(any_hit), .hit_idx(hit_idx));

  vb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_lru (
    .clk(clk), .rst(rst), .slot_valid(slot_valid), .touch(ev_req),
    .touch_idx(tgt), .free_any(free_any), .victim_idx(victim_idx));

  assign take  = look_req && any_hit;
  assign tgt   = take ? hit_idx : victim_idx;
  assign spill = ev_req && !take && !free_any && slot_dirty[tgt];

  always_comb begin
    if (take) op = ev_req ? VB_SWAP : VB_TAKE;
    else      op = ev_req ? VB_FILL : VB_IDLE;
  end

  // Valid bits and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= '0;
      look_done  <= 1'b0;
      look_hit   <= 1'b0;
      look_dirty <= 1'b0;
      look_data  <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      look_done  <= look_req;
      look_hit   <= take;
      look_dirty <= take && slot_dirty[hit_idx];
      look_data  <= take ? slot_data[hit_idx] : '0;
      wb_valid   <= spill;
      wb_addr    <= slot_addr[tgt];
      wb_data    <= slot_data[tgt];
      case (op)
        VB_TAKE: slot_valid[hit_idx] <= 1'b0;
        VB_SWAP, VB_FILL: slot_valid[tgt] <= 1'b1;
        default: ;
      endcase
    end
  end

  // Line storage, no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (ev_req) begin
      slot_addr[tgt]  <= ev_addr;
      slot_data[tgt]  <= ev_data;
      slot_dirty[tgt] <= ev_dirty;
    end
  end

  // R2: a hit only answers a lookup of the previous cycle
  p_hit_after_look_r2: assert property (@(posedge clk) disable iff (rst)
    look_hit |-> (look_done && $past(look_req)));
  // R8: a writeback only follows an eviction
  p_wb_after_evict_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(ev_req));
  // R5: a swap never spills a line
  p_no_wb_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
    look_hit |-> !wb_valid);
  // R1: outputs are quiet on the cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!look_done && !wb_valid));
endmodule

// File: tb/test_victim_buf.sv
module test_victim_buf;
  localparam int CLK_PERIOD = 10;
  localparam int ENT = 4;
  localparam int AW  = 16;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          look_req = 0, ev_req = 0, ev_dirty = 0;
  logic [AW-1:0] look_addr = '0, ev_addr = '0;
  logic [DW-1:0] ev_data = '0;
  logic          look_done, look_hit, look_dirty, wb_valid;
  logic [DW-1:0] look_data, wb_data;
  logic [AW-1:0] wb_addr;

  victim_buf #(.ENTRIES(ENT), .ADDR_W(AW), .DATA_W(DW)) i_victim_buf (
    .clk(clk), .rst(rst), .look_req(look_req), .look_addr(look_addr),
    .ev_req(ev_req), .ev_addr(ev_addr), .ev_data(ev_data), .ev_dirty(ev_dirty),
    .look_done(look_done), .look_hit(look_hit), .look_data(look_data),
    .look_dirty(look_dirty), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wb_data(wb_data));

  // Single-slot instance
  logic          s_look = 0, s_ev = 0, s_evd = 0;
  logic [AW-1:0] s_la = '0, s_ea = '0;
  logic [DW-1:0] s_ed = '0;
  logic          s_done, s_hit, s_hd, s_wbv;
  logic [DW-1:0] s_hdata, s_wbd;
  logic [AW-1:0] s_wba;

  victim_buf #(.ENTRIES(1), .ADDR_W(AW), .DATA_W(DW)) i_victim_buf_one (
    .clk(clk), .rst(rst), .look_req(s_look), .look_addr(s_la),
    .ev_req(s_ev), .ev_addr(s_ea), .ev_data(s_ed), .ev_dirty(s_evd),
    .look_done(s_done), .look_hit(s_hit), .look_data(s_hdata),
    .look_dirty(s_hd), .wb_valid(s_wbv), .wb_addr(s_wba), .wb_data(s_wbd));

  int total = 0, bad = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: slots plus fill timestamps
  bit          m_val [ENT];
  bit [AW-1:0] m_addr [ENT];
  bit [DW-1:0] m_data [ENT];
  bit          m_dirty [ENT];
  int          m_stamp [ENT];
  int          now = 0;
  bit [DW-1:0] mem [16];

  bit          r_hit, r_dirty;
  bit [DW-1:0] r_data;

  task automatic do_op(input string req, input bit lr, input bit [AW-1:0] la,
                       input bit er, input bit [AW-1:0] ea, input bit [DW-1:0] ed,
                       input bit edirty);
    bit e_hit = 0, e_hd = 0, e_wb = 0;
    bit [DW-1:0] e_hdata = '0, e_wbd = '0;
    bit [AW-1:0] e_wba = '0;
    int slot = -1;
    if (lr)
      for (int k = 0; k < ENT; k++)
        if (m_val[k] && m_addr[k] == la) begin
          slot = k; e_hit = 1; e_hdata = m_data[k]; e_hd = m_dirty[k];
        end
    if (e_hit && !er) m_val[slot] = 0;
    if (er) begin
      if (!e_hit) begin
        for (int k = ENT-1; k >= 0; k--) if (!m_val[k]) slot = k;
        if (slot < 0) begin
          slot = 0;
          for (int k = 1; k < ENT; k++) if (m_stamp[k] < m_stamp[slot]) slot = k;
          if (m_dirty[slot]) begin
            e_wb = 1; e_wba = m_addr[slot]; e_wbd = m_data[slot];
            mem[m_addr[slot][3:0]] = m_data[slot];
          end
        end
      end
      now++;
      m_val[slot] = 1; m_addr[slot] = ea; m_data[slot] = ed;
      m_dirty[slot] = edirty; m_stamp[slot] = now;
    end
    look_req = lr; look_addr = la; ev_req = er; ev_addr = ea;
    ev_data = ed; ev_dirty = edirty;
    @(negedge clk);
    look_req = 0; ev_req = 0;
    check(req, "look_done", 64'(look_done), 64'(lr));
    check(req, "look_hit", 64'(look_hit), 64'(e_hit));
    if (e_hit) begin
      check(req, "look_data", 64'(look_data), 64'(e_hdata));
      check(req, "look_dirty", 64'(look_dirty), 64'(e_hd));
    end
    check(req, "wb_valid", 64'(wb_valid), 64'(e_wb));
    if (e_wb) begin
      check(req, "wb_addr", 64'(wb_addr), 64'(e_wba));
      check(req, "wb_data", 64'(wb_data), 64'(e_wbd));
    end
    r_hit = e_hit; r_data = e_hdata; r_dirty = e_hd;
  endtask

  task automatic s_op(input bit lr, input bit [AW-1:0] la, input bit er,
                      input bit [AW-1:0] ea, input bit [DW-1:0] ed, input bit edd);
    s_look = lr; s_la = la; s_ev = er; s_ea = ea; s_ed = ed; s_evd = edd;
    @(negedge clk);
    s_look = 0; s_ev = 0;
  endtask

  // Direct-mapped main cache model: 4 sets, line address = {tag, set}
  bit          mc_val [4];
  bit [AW-1:0] mc_addr [4];
  bit [DW-1:0] mc_data [4];
  bit          mc_dirty [4];

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 32'h1000 + k;
    for (int k = 0; k < ENT; k++) begin m_val[k] = 0; m_stamp[k] = 0; end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    check("R1", "look_done in reset", 64'(look_done), 0);
    check("R1", "wb_valid in reset", 64'(wb_valid), 0);
    rst = 0;
    check("R1", "look_hit after reset", 64'(look_hit), 0);
    do_op("R1", 1, 16'h0005, 0, 0, 0, 0);
    // R6: fill free slots, no writeback
    do_op("R6", 0, 0, 1, 16'h0011, 32'hA1, 1);
    do_op("R6", 0, 0, 1, 16'h0022, 32'hA2, 0);
    do_op("R6", 0, 0, 1, 16'h0033, 32'hA3, 1);
    do_op("R6", 0, 0, 1, 16'h0044, 32'hA4, 0);
    // R2: hit returns data and flag; R4: then gone
    do_op("R2", 1, 16'h0033, 0, 0, 0, 0);
    do_op("R4", 1, 16'h0033, 0, 0, 0, 0);
    // R3: miss on unknown address differing only in tag bits
    do_op("R3", 1, 16'h0133, 0, 0, 0, 0);
    // R5: swap, then evicted line is found
    do_op("R5", 1, 16'h0022, 1, 16'h0055, 32'hB5, 1);
    do_op("R6", 0, 0, 1, 16'h0066, 32'hA6, 1);
    // R7/R8: full, oldest fill is 0x11 (dirty) -> writeback
    do_op("R8", 0, 0, 1, 16'h0077, 32'hA7, 0);
    // next oldest 0x44 clean -> dropped
    do_op("R8", 0, 0, 1, 16'h0088, 32'hA8, 0);
    do_op("R5", 1, 16'h0055, 0, 0, 0, 0);
    do_op("R7", 1, 16'h0011, 0, 0, 0, 0);
    // drain remaining lines
    do_op("R2", 1, 16'h0066, 0, 0, 0, 0);
    do_op("R2", 1, 16'h0077, 0, 0, 0, 0);
    do_op("R2", 1, 16'h0088, 0, 0, 0, 0);

    // Random traffic through a main cache model
    for (int k = 0; k < 16; k++) mem[k] = 32'h2000 + k;
    for (int k = 0; k < 4; k++) mc_val[k] = 0;
    for (int n = 0; n < 3000; n++) begin
      bit [3:0] a = 4'($urandom_range(15));
      int i = int'(a[1:0]);
      bit wr = ($urandom_range(3) == 0);
      if (mc_val[i] && mc_addr[i] == AW'(a)) begin
        if (wr) begin mc_data[i] = $urandom; mc_dirty[i] = 1; end
      end else begin
        do_op(mc_val[i] ? "R7" : "R3", 1, AW'(a), mc_val[i], mc_addr[i],
              mc_data[i], mc_dirty[i]);
        mc_val[i] = 1; mc_addr[i] = AW'(a);
        if (r_hit) begin mc_data[i] = r_data; mc_dirty[i] = r_dirty; end
        else begin mc_data[i] = mem[a]; mc_dirty[i] = 0; end
        if (wr) begin mc_data[i] = $urandom; mc_dirty[i] = 1; end
      end
    end

    // R9: single-slot instance
    s_op(1, 16'h0009, 0, 0, 0, 0);
    check("R9", "single miss", 64'(s_hit), 0);
    s_op(0, 0, 1, 16'h0001, 32'hC1, 1);
    check("R9", "single fill wb", 64'(s_wbv), 0);
    s_op(0, 0, 1, 16'h0002, 32'hC2, 0);
    check("R9", "single wb_valid", 64'(s_wbv), 1);
    check("R9", "single wb_addr", 64'(s_wba), 64'h0001);
    check("R9", "single wb_data", 64'(s_wbd), 64'hC1);
    s_op(1, 16'h0002, 1, 16'h0003, 32'hC3, 1);
    check("R9", "single swap hit", 64'(s_hit), 1);
    check("R9", "single swap data", 64'(s_hdata), 64'hC2);
    check("R9", "single swap wb", 64'(s_wbv), 0);
    s_op(1, 16'h0003, 0, 0, 0, 0);
    check("R9", "single hit data", 64'(s_hdata), 64'hC3);
    check("R9", "single hit dirty", 64'(s_hd), 1);
    s_op(1, 16'h0003, 0, 0, 0, 0);
    check("R9", "single emptied", 64'(s_hit), 0);
    finish_run();
  end
endmodule